// File: doc/BRIEF.md
# Universal Latch/Register Bus Transceiver

This block links two data buses, side A and side B, in both directions. Each direction passes data through a storage element with three modes. While the direction's latch enable is high, the element is open and the far side follows the near side with no register in the path. While the latch enable is low, the element holds its value. A rising edge on the direction's own clock input loads a new value. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low.

The width is split into independent halves. By default there are two halves of 18 bits each. Every half has its own six controls: a latch enable, a clock and an output enable for each direction. The pads are presented as separate input, output and output-enable vectors, so the block can be synthesized without internal tristates. A per-bit "driven" mask models the pads' bus-hold keepers. When a bit's mask is low, that input reads as the last level it had while driven.

The whole block runs on a fast system clock. The direction clocks are sampled on this clock and an edge detector finds their rising edges. A synchronous active-low reset clears every stored value and every keeper to zero.

Top module: `ubt_xcvr`

## Requirements
- R1: With a direction's latch enable high, its output bits equal the (keeper-resolved) input bits of the opposite side in the same cycle, with no clock delay.
- R2: With the latch enable low and the direction clock not rising, the output keeps its stored value while the input changes.
- R3: With the latch enable low, a direction-clock rising edge (low on one system-clock sample, high on the next) stores the input sampled at that system-clock edge. The new value is visible from the following cycle.
- R4: When the latch enable falls, the output holds the input that was present on the last system-clock cycle in which the enable was high.
- R5: The A-to-B enable is active high. `b_oe` of a half is all ones when its `ab_oe` bit is 1 and all zeros when it is 0. A clock edge while the enable is off still loads data, and that data is shown once the enable returns.
- R6: The B-to-A enable is active low. `a_oe` of a half is all ones when its `ba_oe_n` bit is 0 and all zeros when it is 1. In every other respect the direction behaves as in R1 to R4 and R10.
- R7: Half h owns bits [h*18 +: 18]. Its controls leave the outputs and output enables of the other half, and of the opposite direction, unchanged.
- R8: An input bit whose driven-mask bit is 0 reads as the value that bit last had while its mask was 1. A keeper that has never seen a driven value since reset reads as 0.
- R9: A synchronous reset (`rst_n` low at a clock edge) clears all stored values to 0, so that every output reads 0 after reset while the latch enables are low.
- R10: A falling edge of a direction clock does not load data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_in | input | 36 | Side A pad input levels |
| a_drv | input | 36 | 1 = side A input bit is actively driven |
| b_in | input | 36 | Side B pad input levels |
| b_drv | input | 36 | 1 = side B input bit is actively driven |
| ab_le | input | 2 | A-to-B latch enable, one per half |
| ab_ck | input | 2 | A-to-B storage clock, one per half |
| ab_oe | input | 2 | A-to-B output enable, active high, one per half |
| ba_le | input | 2 | B-to-A latch enable, one per half |
| ba_ck | input | 2 | B-to-A storage clock, one per half |
| ba_oe_n | input | 2 | B-to-A output enable, active low, one per half |
| b_out | output | 36 | Data driven onto side B |
| b_oe | output | 36 | Per-bit drive enable for side B |
| a_out | output | 36 | Data driven onto side A |
| a_oe | output | 36 | Per-bit drive enable for side A |

## Verification
A corrupted stored word is invisible while the latch is open. It appears on the output pins in the first cycle the latch enable is low, and it stays there until the next direction-clock edge or until the latch reopens. A wrong edge detector shows either as a load one system cycle late, as a load on the falling edge, or as a missed load. Each of these is caught by sampling the output one cycle after the edge. A keeper that tracks the wrong level shows up in the same cycle as a wrong output bit, but only once its mask bit drops and only on a transparent path.

// File: rtl/ubt_pkg.sv
// Package: shared sizing for the universal bus transceiver.
// Assumes: halves are all the same width.
package ubt_pkg;
    localparam int UBT_HALF_W = 18;  // bits per independent half
    localparam int UBT_HALVES = 2;   // number of halves
endpackage

// File: rtl/ubt_keeper.sv
// Module: ubt_keeper
// Models a bus-hold keeper on every input bit. A driven bit passes
// straight through; an undriven bit reads the last driven level.
// Assumes: the driven mask is synchronous to clk; reset value is 0.
module ubt_keeper #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] drv,
    output logic [W-1:0] val
);
    logic [W-1:0] held;

    // Resolve each bit: the pad level when driven, else the kept level.
    always_comb begin
        val = (pin & drv) | (held & ~drv);
    end

    // Track the resolved level so it survives the pad being released.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= val;
    end

    // R8: an undriven bit does not move from one cycle to the next
    p_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((val ^ $past(val)) & ~drv) == '0));
endmodule

// File: rtl/ubt_store.sv
// Module: ubt_store
// One direction's storage element. It is transparent while le is high,
// holds while le is low, and loads on a rising edge of ck (sampled on
// clk) while le is low. The transparent path has no register in it.
// Assumes: ck changes no faster than once per clk cycle.
module ubt_store #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         ck,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] mem;
    logic         ck_s;
    logic         ck_rise;

    // Remember the previous ck sample; this runs during reset too.
    always_ff @(posedge clk) begin
        ck_s <= ck;
    end

    // Detect a low-to-high step of the direction clock.
    always_comb begin
        ck_rise = ck & ~ck_s;
    end

    // Load while open, or on a clock edge while closed.
    always_ff @(posedge clk) begin
        if (!rst_n)              mem <= '0;
        else if (le || ck_rise)  mem <= d;
    end

    // Pass the input through while open, else show the stored word.
    always_comb begin
        q = le ? d : mem;
    end

    // R2: closed and no edge keeps the output steady
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !ck_rise) ##1 !le |-> q == $past(q));
    // R3: an edge while closed shows the sampled input next cycle
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && ck_rise) ##1 !le |-> q == $past(d));
    // R4: closing keeps the input seen in the last open cycle
    p_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(le) && $past(rst_n)) |-> q == $past(d));
endmodule

// File: rtl/ubt_half.sv
// Module: ubt_half
// One independent half: an A-to-B and a B-to-A storage element, each with
// its own controls, plus per-bit drive enables of opposite polarity.
// Assumes: its inputs have already been resolved by the keepers.
module ubt_half #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_val,
    input  logic [W-1:0] b_val,
    input  logic         ab_le,
    input  logic         ab_ck,
    input  logic         ab_oe,
    input  logic         ba_le,
    input  logic         ba_ck,
    input  logic         ba_oe_n,
    output logic [W-1:0] b_q,
    output logic [W-1:0] b_en,
    output logic [W-1:0] a_q,
    output logic [W-1:0] a_en
);
    ubt_store #(.W(W)) i_ab (
        .clk(clk), .rst_n(rst_n), .le(ab_le), .ck(ab_ck), .d(a_val), .q(b_q)
    );

    ubt_store #(.W(W)) i_ba (
        .clk(clk), .rst_n(rst_n), .le(ba_le), .ck(ba_ck), .d(b_val), .q(a_q)
    );

    // Widen the enables; A-to-B is active high, B-to-A is active low.
    always_comb begin
        b_en = {W{ab_oe}};
        a_en = {W{~ba_oe_n}};
    end
endmodule

// File: rtl/ubt_xcvr.sv
// Module: ubt_xcvr (top)
// Bidirectional universal bus transceiver built from independent halves.
// The pads are split into in / out / enable vectors; a driven mask per
// input bit feeds the bus-hold keepers.
// Assumes: a single fast system clock; a synchronous active-low reset.
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int HALF_W = UBT_HALF_W,
    parameter int HALVES = UBT_HALVES,
    localparam int W     = HALF_W * HALVES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      a_in,
    input  logic [W-1:0]      a_drv,
    input  logic [W-1:0]      b_in,
    input  logic [W-1:0]      b_drv,
    input  logic [HALVES-1:0] ab_le,
    input  logic [HALVES-1:0] ab_ck,
    input  logic [HALVES-1:0] ab_oe,
    input  logic [HALVES-1:0] ba_le,
    input  logic [HALVES-1:0] ba_ck,
    input  logic [HALVES-1:0] ba_oe_n,
    output logic [W-1:0]      b_out,
    output logic [W-1:0]      b_oe,
    output logic [W-1:0]      a_out,
    output logic [W-1:0]      a_oe
);
    logic [W-1:0] a_val;
    logic [W-1:0] b_val;

    ubt_keeper #(.W(W)) i_keep_a (
        .clk(clk), .rst_n(rst_n), .pin(a_in), .drv(a_drv), .val(a_val)
    );

    ubt_keeper #(.W(W)) i_keep_b (
        .clk(clk), .rst_n(rst_n), .pin(b_in), .drv(b_drv), .val(b_val)
    );

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        ubt_half #(.W(HALF_W)) i_half (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_val   (a_val[h*HALF_W +: HALF_W]),
            .b_val   (b_val[h*HALF_W +: HALF_W]),
            .ab_le   (ab_le[h]),
            .ab_ck   (ab_ck[h]),
            .ab_oe   (ab_oe[h]),
            .ba_le   (ba_le[h]),
            .ba_ck   (ba_ck[h]),
            .ba_oe_n (ba_oe_n[h]),
            .b_q     (b_out[h*HALF_W +: HALF_W]),
            .b_en    (b_oe[h*HALF_W +: HALF_W]),
            .a_q     (a_out[h*HALF_W +: HALF_W]),
            .a_en    (a_oe[h*HALF_W +: HALF_W])
        );
    end
endmodule

// File: tb/test_ubt_xcvr.sv
module test_ubt_xcvr;
    localparam int HW = 18;
    localparam int NH = 2;
    localparam int W  = HW * NH;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a_in = '0, a_drv = '1, b_in = '0, b_drv = '1;
    logic [NH-1:0] ab_le = '0, ab_ck = '0, ab_oe = '0;
    logic [NH-1:0] ba_le = '0, ba_ck = '0, ba_oe_n = '1;
    logic [W-1:0]  b_out, b_oe, a_out, a_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    ubt_xcvr i_ubt_xcvr (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_drv(a_drv), .b_in(b_in), .b_drv(b_drv),
        .ab_le(ab_le), .ab_ck(ab_ck), .ab_oe(ab_oe),
        .ba_le(ba_le), .ba_ck(ba_ck), .ba_oe_n(ba_oe_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
    );

    typedef struct packed {
        logic          en;   // logical enable (polarity applied per direction)
        logic          le;
        logic          ck;
        logic [HW-1:0] d;
        logic [HW-1:0] exp;
        logic [7:0]    req;
    } row_t;

    // Rows are driven after a reset; exp is the output seen in that row.
    localparam row_t TBL [12] = '{
        '{1'b1, 1'b0, 1'b0, 18'h15A5A, 18'h00000, 8'd9},  // R9 cleared
        '{1'b1, 1'b1, 1'b0, 18'h12345, 18'h12345, 8'd1},  // R1 open
        '{1'b1, 1'b1, 1'b0, 18'h0F0F0, 18'h0F0F0, 8'd1},  // R1 open
        '{1'b1, 1'b0, 1'b0, 18'h33333, 18'h0F0F0, 8'd4},  // R4 closed
        '{1'b1, 1'b0, 1'b0, 18'h22222, 18'h0F0F0, 8'd2},  // R2 hold
        '{1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h0F0F0, 8'd3},  // R3 edge row
        '{1'b1, 1'b0, 1'b1, 18'h11111, 18'h2AAAA, 8'd3},  // R3 loaded
        '{1'b1, 1'b0, 1'b0, 18'h3C3C3, 18'h2AAAA, 8'd10}, // R10 fall
        '{1'b0, 1'b0, 1'b0, 18'h00000, 18'h00000, 8'd5},  // R5 off
        '{1'b0, 1'b0, 1'b1, 18'h01234, 18'h00000, 8'd5},  // R5 edge while off
        '{1'b1, 1'b0, 1'b1, 18'h3FFFF, 18'h01234, 8'd5},  // R5 shown again
        '{1'b1, 1'b0, 1'b0, 18'h00000, 18'h01234, 8'd2}   // R2 hold
    };

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        a_in = '0; b_in = '0; a_drv = '1; b_drv = '1;
        ab_le = '0; ab_ck = '0; ab_oe = '0;
        ba_le = '0; ba_ck = '0; ba_oe_n = '1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_all();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drive(input int dir, input int h, input logic en, input logic le,
                         input logic ck, input logic [HW-1:0] d);
        if (dir == 0) begin
            ab_oe[h] = en; ab_le[h] = le; ab_ck[h] = ck; a_in[h*HW +: HW] = d;
        end else begin
            ba_oe_n[h] = ~en; ba_le[h] = le; ba_ck[h] = ck; b_in[h*HW +: HW] = d;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // Table walk: each direction in each half.
        for (int dir = 0; dir < 2; dir++) begin
            for (int h = 0; h < NH; h++) begin
                do_reset();
                for (int r = 0; r < 12; r++) begin
                    logic [HW-1:0] o, e, oo, oe2;
                    logic [W-1:0]  rev_oe;
                    string tag;
                    @(negedge clk);
                    drive(dir, h, TBL[r].en, TBL[r].le, TBL[r].ck, TBL[r].d);
                    #2;
                    tag = $sformatf("R%0d dir%0d half%0d row%0d", TBL[r].req, dir, h, r);
                    o   = (dir == 0) ? b_out[h*HW +: HW] : a_out[h*HW +: HW];
                    e   = (dir == 0) ? b_oe[h*HW +: HW]  : a_oe[h*HW +: HW];
                    if (TBL[r].en)
                        check(e == '1 && o == TBL[r].exp, tag, {e, o}, {{HW{1'b1}}, TBL[r].exp});
                    else
                        check(e == '0, tag, {{HW{1'b0}}, e}, '0);  // R5 R6 high impedance
                    // R7: the other half and the opposite direction stay untouched
                    oo     = (dir == 0) ? b_out[(1-h)*HW +: HW] : a_out[(1-h)*HW +: HW];
                    oe2    = (dir == 0) ? b_oe[(1-h)*HW +: HW]  : a_oe[(1-h)*HW +: HW];
                    rev_oe = (dir == 0) ? a_oe : b_oe;
                    check(oo == '0 && oe2 == '0 && rev_oe == '0,
                          $sformatf("R7 dir%0d half%0d row%0d", dir, h, r),
                          {oo, oe2}, '0);
                end
            end
        end

        // R6: B-to-A enable polarity, directed
        do_reset();
        @(negedge clk); ba_oe_n = 2'b10; #2;
        check(a_oe == {{HW{1'b0}}, {HW{1'b1}}}, "R6 low enables", a_oe,
              {{HW{1'b0}}, {HW{1'b1}}});
        @(negedge clk); ba_oe_n = 2'b11; #2;
        check(a_oe == '0, "R6 high disables", a_oe, '0);

        // R8: keeper holds undriven bits on a transparent A-to-B path
        do_reset();
        @(negedge clk); drive(0, 0, 1'b1, 1'b1, 1'b0, 18'h2B3C1); #2;
        check(b_out[HW-1:0] == 18'h2B3C1, "R8 driven pass", b_out, 36'h2B3C1);
        @(negedge clk); a_in[HW-1:0] = 18'h00007; a_drv[HW-1:0] = '0; #2;
        check(b_out[HW-1:0] == 18'h2B3C1, "R8 all undriven", b_out, 36'h2B3C1);
        @(negedge clk); a_in[HW-1:0] = 18'h3FFFF; a_drv[HW-1:0] = 18'h3FE00; #2;
        check(b_out[HW-1:0] == 18'h3FFC1, "R8 partly undriven", b_out, 36'h3FFC1);

        // R8 R9: keeper reads 0 after reset when never driven
        do_reset();
        @(negedge clk); b_drv = '0; b_in = '1; drive(1, 1, 1'b1, 1'b1, 1'b0, 18'h3FFFF); #2;
        check(a_out == '0 && a_oe[W-1:HW] == '1, "R8 R9 keeper reset", a_out, '0);

        // R9: reset in the middle of held data clears it
        @(negedge clk); b_drv = '1; b_in = '0;
        drive(0, 1, 1'b1, 1'b1, 1'b0, 18'h1ABCD);
        @(negedge clk); ab_le[1] = 1'b0; #2;
        check(b_out[W-1:HW] == 18'h1ABCD, "R4 before reset", b_out, {18'h1ABCD, 18'h0});
        do_reset();
        @(negedge clk); ab_oe[1] = 1'b1; #2;
        check(b_out == '0, "R9 reset clears", b_out, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule